// File: doc/BRIEF.md
# Write-Through Data Cache Controller with One-Entry Write Buffer

This block sits between a processor's data port and a backing memory bus. It keeps a direct-mapped array of one-word lines and follows a write-through policy: every store goes to memory, and a store that misses the array does not claim a line. Stores leave through a single-entry write buffer, so the processor gets its acknowledge before the memory write has finished. A second store has to wait only if the buffer is still occupied.

Each request carries attributes that decide two things. The first is whether the data may be cached: data that can be reached only across the inter-cluster network is never cached, and instruction fetches are always cached. The second is how the memory cycle is routed: a coherent store to this node's own memory, into a block whose sharing bit is set, is sent as an invalidating cycle on the external data bus. Other local traffic stays off that bus. A separate snoop input removes a matching line when another agent writes to that address.

Top module: `wtc_ctrl`

## Requirements
- R1: After reset every line is invalid, the write buffer is empty, and `cpu_ack` and `mem_req` are 0. The first read of any address therefore goes to memory.
- R2: A cacheable read that hits returns the line data with `cpu_ack` high in the cycle after the accepting clock edge (one cycle). It issues no memory request.
- R3: A store is acknowledged two cycles after it is accepted when the buffer is empty, and it reaches memory through the buffer. A store that misses leaves the array unchanged, so a later read of that address goes to memory.
- R4: A store that hits updates the line and loads the buffer in the same operation. A later read hits and returns the new data.
- R5: A data request with `cpu_remote`=1 is never cached. Repeated reads each go to memory, and for such requests `mem_ext`=1.
- R6: A request with `cpu_fetch`=1 is a cacheable read even when `cpu_remote`=1, and `cpu_we` is ignored for it.
- R7: A store with `cpu_coh`=1, `cpu_local`=1 and `cpu_shared`=1 is issued with `mem_inval`=1 and `mem_ext`=1. A local store without all three is issued with both at 0. A non-local store has `mem_ext`=1 and `mem_inval`=0.
- R8: The buffer holds one store. A store that arrives while it is occupied is not acknowledged until the buffered store has drained.
- R9: A read that misses the array but matches the buffered address returns the buffered data in one cycle, with no memory read.
- R10: A read miss to any other address waits until the buffer has drained, then reads memory.
- R11: `snp_inval` with an address whose tag matches a valid line clears that line. A snoop that hits the same index with a different tag leaves the line valid.
- R12: Once `mem_req` is raised, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable until `mem_ack`.
- R13: `cpu_ack` is a one-cycle pulse and only follows a request that was held in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_fetch | input | 1 | Instruction fetch (always a cacheable read) |
| cpu_remote | input | 1 | Target reachable only through the inter-cluster network |
| cpu_coh | input | 1 | Coherent access |
| cpu_local | input | 1 | Target is this node's own memory |
| cpu_shared | input | 1 | Sharing bit of the target block |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Store data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Load data, valid with `cpu_ack` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = write cycle |
| mem_ext | output | 1 | Cycle uses the external data bus |
| mem_inval | output | 1 | Write also invalidates other copies in the cluster |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory completion, read data valid |
| mem_rdata | input | DW | Memory read data |
| snp_inval | input | 1 | Snooped invalidation strobe |
| snp_addr | input | AW | Snooped address |

## Verification
The assertions check the memory handshake on every cycle: the request and its fields stay stable until the acknowledge, and an invalidating cycle is always an external write. They also check that the processor acknowledge is a single pulse that answers a held request. Everything else can only be shown by the bench's scenarios, because it depends on earlier history: hit versus miss latency, allocation only on read misses, forwarding from the buffer, the stall on a second store, drain-before-read ordering, the cacheability of remote data versus fetches, and which line a snoop removes.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_MISS  = 2'd2,
        ST_DONE  = 2'd3
    } wtc_state_e;
endpackage

// File: rtl/wtc_lines.sv
// Direct-mapped line store: valid, tag and one data word per line.
module wtc_lines #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int LINES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] look_addr,
    output logic          look_hit,
    output logic [DW-1:0] look_data,
    input  logic          upd_en,
    input  logic [AW-1:0] upd_addr,
    input  logic [DW-1:0] upd_data,
    input  logic          snp_en,
    input  logic [AW-1:0] snp_addr
);
    localparam int IW = $clog2(LINES);
    localparam int TW = AW - IW;

    typedef struct packed {
        logic [LINES-1:0]         vld;
        logic [LINES-1:0][TW-1:0] tag;
        logic [LINES-1:0][DW-1:0] dat;
    } lines_t;

    lines_t lines_d, lines_q;

    logic [IW-1:0] look_idx, upd_idx, snp_idx;
    logic [TW-1:0] look_tag, upd_tag, snp_tag;

    assign look_idx = look_addr[IW-1:0];
    assign look_tag = look_addr[AW-1:IW];
    assign upd_idx  = upd_addr[IW-1:0];
    assign upd_tag  = upd_addr[AW-1:IW];
    assign snp_idx  = snp_addr[IW-1:0];
    assign snp_tag  = snp_addr[AW-1:IW];

    assign look_hit  = lines_q.vld[look_idx] && (lines_q.tag[look_idx] == look_tag);
    assign look_data = lines_q.dat[look_idx];

    always_comb begin
        lines_d = lines_q;
        if (upd_en) begin
            lines_d.vld[upd_idx] = 1'b1;
            lines_d.tag[upd_idx] = upd_tag;
            lines_d.dat[upd_idx] = upd_data;
        end
        // a snoop seen together with an update wins on the same line
        if (snp_en && lines_d.vld[snp_idx] && (lines_d.tag[snp_idx] == snp_tag)) begin
            lines_d.vld[snp_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lines_q <= '0;
        else        lines_q <= lines_d;
    end
endmodule

// File: rtl/wtc_wbuf.sv
// Single-entry posted write buffer; drains on the memory acknowledge.
module wtc_wbuf #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic          ld_inval,
    input  logic          ld_ext,
    input  logic          mem_ack,
    output logic          busy,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data,
    output logic          inval,
    output logic          ext
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          inval;
        logic          ext;
    } entry_t;

    entry_t ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (ent_q.vld && mem_ack) ent_d.vld = 1'b0;
        if (load) begin
            ent_d.vld   = 1'b1;
            ent_d.addr  = ld_addr;
            ent_d.data  = ld_data;
            ent_d.inval = ld_inval;
            ent_d.ext   = ld_ext;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign busy  = ent_q.vld;
    assign addr  = ent_q.addr;
    assign data  = ent_q.data;
    assign inval = ent_q.inval;
    assign ext   = ent_q.ext;
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int LINES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic          cpu_fetch,
    input  logic          cpu_remote,
    input  logic          cpu_coh,
    input  logic          cpu_local,
    input  logic          cpu_shared,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_ack,
    output logic [DW-1:0] cpu_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_ext,
    output logic          mem_inval,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    input  logic          snp_inval,
    input  logic [AW-1:0] snp_addr
);
    import wtc_pkg::*;

    typedef struct packed {
        wtc_state_e    st;
        logic          ack;
        logic [DW-1:0] rdata;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          cach;
        logic          inval;
        logic          ext;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [AW-1:0] look_addr;
    logic          look_hit;
    logic [DW-1:0] look_data;
    logic          upd_en;
    logic [DW-1:0] upd_data;
    logic          wb_load, wb_busy, wb_inval, wb_ext;
    logic [AW-1:0] wb_addr;
    logic [DW-1:0] wb_data;
    logic          is_rd, cach_in, inval_in, wb_match;

    assign look_addr = (ctl_q.st == ST_IDLE) ? cpu_addr : ctl_q.addr;
    assign is_rd     = !cpu_we || cpu_fetch;
    assign cach_in   = cpu_fetch || !cpu_remote;
    assign inval_in  = !is_rd && cpu_coh && cpu_local && cpu_shared;
    assign wb_match  = wb_busy && (wb_addr == cpu_addr);

    wtc_lines #(.AW(AW), .DW(DW), .LINES(LINES)) u_lines (
        .clk(clk), .rst_n(rst_n),
        .look_addr(look_addr), .look_hit(look_hit), .look_data(look_data),
        .upd_en(upd_en), .upd_addr(ctl_q.addr), .upd_data(upd_data),
        .snp_en(snp_inval), .snp_addr(snp_addr)
    );

    wtc_wbuf #(.AW(AW), .DW(DW)) u_wbuf (
        .clk(clk), .rst_n(rst_n),
        .load(wb_load), .ld_addr(ctl_q.addr), .ld_data(ctl_q.wdata),
        .ld_inval(ctl_q.inval), .ld_ext(ctl_q.ext),
        .mem_ack(mem_ack), .busy(wb_busy), .addr(wb_addr), .data(wb_data),
        .inval(wb_inval), .ext(wb_ext)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.ack = 1'b0;
        upd_en    = 1'b0;
        upd_data  = ctl_q.wdata;
        wb_load   = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (is_rd && cach_in && look_hit) begin
                        ctl_d.ack   = 1'b1;
                        ctl_d.rdata = look_data;
                        ctl_d.st    = ST_DONE;
                    end else if (is_rd && wb_match) begin
                        ctl_d.ack   = 1'b1;
                        ctl_d.rdata = wb_data;
                        ctl_d.st    = ST_DONE;
                    end else if (!wb_busy) begin
                        ctl_d.addr  = cpu_addr;
                        ctl_d.wdata = cpu_wdata;
                        ctl_d.cach  = cach_in;
                        ctl_d.inval = inval_in;
                        ctl_d.ext   = !cpu_local || inval_in;
                        ctl_d.st    = is_rd ? ST_MISS : ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                upd_en    = ctl_q.cach && look_hit;
                wb_load   = 1'b1;
                ctl_d.ack = 1'b1;
                ctl_d.st  = ST_DONE;
            end
            ST_MISS: begin
                if (mem_ack) begin
                    upd_en      = ctl_q.cach;
                    upd_data    = mem_rdata;
                    ctl_d.ack   = 1'b1;
                    ctl_d.rdata = mem_rdata;
                    ctl_d.st    = ST_DONE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // memory port: a pending store owns it; a miss is only started once the buffer is empty
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_ext   = 1'b0;
        mem_inval = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        if (wb_busy) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_ext   = wb_ext;
            mem_inval = wb_inval;
            mem_addr  = wb_addr;
            mem_wdata = wb_data;
        end else if (ctl_q.st == ST_MISS) begin
            mem_req  = 1'b1;
            mem_ext  = ctl_q.ext;
            mem_addr = ctl_q.addr;
        end
    end

    assign cpu_ack   = ctl_q.ack;
    assign cpu_rdata = ctl_q.rdata;
endmodule

// File: rtl/wtc_ctrl_chk.sv
module wtc_ctrl_chk #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_req,
    input logic          cpu_ack,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_we,
    input logic          mem_ext,
    input logic          mem_inval,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata
);
    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R12
    wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_ack) |=> $stable(mem_wdata));

    // R7
    inval_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_inval) |-> (mem_we && mem_ext));

    // R13
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    // R13
    ack_answers_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_ack) |-> $past(cpu_req));
endmodule

bind wtc_ctrl wtc_ctrl_chk #(.AW(AW), .DW(DW)) u_wtc_chk (.*);

// File: tb/wtc_ctrl_tb_top.sv
`timescale 1ns/1ps
module wtc_ctrl_tb_top;
    localparam int AW      = 16;
    localparam int DW      = 32;
    localparam int MEM_LAT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 0, cpu_we = 0, cpu_fetch = 0, cpu_remote = 0;
    logic          cpu_coh = 0, cpu_local = 1, cpu_shared = 0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ack;
    logic [DW-1:0] cpu_rdata;
    logic          mem_req, mem_we, mem_ext, mem_inval;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          snp_inval = 1'b0;
    logic [AW-1:0] snp_addr = '0;

    always #10 clk = ~clk;

    wtc_ctrl #(.AW(AW), .DW(DW), .LINES(16)) dut_i (.*);

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] fdef(input logic [AW-1:0] a);
        return {a, ~a};
    endfunction

    // ---------------- memory model ----------------
    logic [DW-1:0] mem_store [int];
    int            rd_cnt = 0, wr_cnt = 0;
    logic          last_inval = 0, last_ext = 0;

    initial begin
        int            cnt = 0;
        logic [AW-1:0] h_addr = '0;
        logic          h_we = 0;
        bit            h_ok = 1;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                cnt     = 0;
            end else if (mem_req) begin
                if (cnt == 0) begin
                    h_addr = mem_addr;
                    h_we   = mem_we;
                    h_ok   = 1;
                end else if (mem_addr != h_addr || mem_we != h_we) begin
                    h_ok = 0;
                end
                cnt++;
                if (cnt == MEM_LAT) begin
                    if (mem_we) begin
                        mem_store[int'(mem_addr)] = mem_wdata;
                        wr_cnt++;
                        last_inval = mem_inval;
                    end else begin
                        mem_rdata = mem_store.exists(int'(mem_addr)) ?
                                    mem_store[int'(mem_addr)] : fdef(mem_addr);
                        rd_cnt++;
                    end
                    last_ext = mem_ext;
                    mem_ack  = 1'b1;
                    cnt      = 0;
                    check(h_ok, "R12 request held stable", {31'd0, h_ok}, 32'd1);
                end
            end else begin
                cnt = 0;
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit            rd;
        logic [DW-1:0] d;
        string         req;
    } sb_t;
    sb_t sbq[$];

    initial begin
        forever begin
            @(negedge clk);
            if (cpu_ack) begin
                if (sbq.size() == 0) begin
                    check(0, "R13 unexpected ack", 32'd1, 32'd0);
                end else begin
                    sb_t it;
                    it = sbq.pop_front();
                    if (it.rd) check(cpu_rdata === it.d, it.req, cpu_rdata, it.d);
                end
            end
        end
    end

    task automatic cpu_op(input bit we, input bit fetch, input bit remote, input bit coh,
                          input bit loc, input bit shared, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, input logic [DW-1:0] exp,
                          input string req, output int lat);
        sb_t it;
        it.rd  = !we || fetch;
        it.d   = exp;
        it.req = req;
        sbq.push_back(it);
        cpu_we = we; cpu_fetch = fetch; cpu_remote = remote; cpu_coh = coh;
        cpu_local = loc; cpu_shared = shared; cpu_addr = a; cpu_wdata = wd;
        cpu_req = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_ack && lat < 500);
        cpu_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain();
        for (int i = 0; i < 200; i++) begin
            if (!mem_req && !mem_ack) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic snoop(input logic [AW-1:0] a);
        snp_addr  = a;
        snp_inval = 1'b1;
        @(negedge clk);
        snp_inval = 1'b0;
        @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- scenarios ----------------
    localparam logic [AW-1:0] A = 16'h0010, B = 16'h0123, C = 16'h0204, E = 16'h0205;
    localparam logic [AW-1:0] F = 16'h0306, G = 16'h0407, H = 16'h8008, I = 16'h9009;
    localparam logic [AW-1:0] J = 16'h000A, K = 16'h700B;

    initial begin
        int lat, r0, w0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cpu_ack == 0, "R1 cpu_ack after reset", {31'd0, cpu_ack}, 32'd0);
        check(mem_req == 0, "R1 mem_req after reset", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: empty array, first read goes to memory
        r0 = rd_cnt;
        cpu_op(0, 0, 0, 0, 1, 0, A, '0, fdef(A), "R1 first read data", lat);
        check(rd_cnt == r0 + 1, "R1 first read misses", rd_cnt, r0 + 1);

        // R2: read hit, one cycle, no memory read
        r0 = rd_cnt;
        cpu_op(0, 0, 0, 0, 1, 0, A, '0, fdef(A), "R2 hit data", lat);
        check(lat == 1, "R2 hit latency", lat, 1);
        check(rd_cnt == r0, "R2 hit no memory read", rd_cnt, r0);

        // R3/R4/R7: write hit, local non-shared
        w0 = wr_cnt;
        cpu_op(1, 0, 0, 1, 1, 0, A, 32'hDEAD_0001, '0, "R3 write", lat);
        check(lat == 2, "R3 write latency", lat, 2);
        drain();
        check(wr_cnt == w0 + 1, "R3 write reaches memory", wr_cnt, w0 + 1);
        check(mem_store[int'(A)] == 32'hDEAD_0001, "R3 memory data", mem_store[int'(A)], 32'hDEAD_0001);
        check(last_inval == 0 && last_ext == 0, "R7 local unshared write stays local",
              {30'd0, last_inval, last_ext}, 32'd0);
        r0 = rd_cnt;
        cpu_op(0, 0, 0, 0, 1, 0, A, '0, 32'hDEAD_0001, "R4 updated line data", lat);
        check(rd_cnt == r0, "R4 read after write hit stays in cache", rd_cnt, r0);

        // R9 then R3 no-allocate
        r0 = rd_cnt;
        cpu_op(1, 0, 0, 0, 1, 0, B, 32'hBEEF_0002, '0, "R3 write miss", lat);
        cpu_op(0, 0, 0, 0, 1, 0, B, '0, 32'hBEEF_0002, "R9 forwarded data", lat);
        check(lat == 1, "R9 forward latency", lat, 1);
        check(rd_cnt == r0, "R9 no memory read", rd_cnt, r0);
        drain();
        cpu_op(0, 0, 0, 0, 1, 0, B, '0, 32'hBEEF_0002, "R3 read after write miss data", lat);
        check(rd_cnt == r0 + 1, "R3 write miss did not allocate", rd_cnt, r0 + 1);

        // R8: second store stalls behind the occupied buffer
        cpu_op(1, 0, 0, 0, 1, 0, C, 32'h0000_C0C0, '0, "R8 first store", lat);
        cpu_op(1, 0, 0, 0, 1, 0, E, 32'h0000_E0E0, '0, "R8 second store", lat);
        check(lat > 2, "R8 second store stalled", lat, 3);
        drain();
        check(mem_store[int'(C)] == 32'h0000_C0C0, "R8 first store data", mem_store[int'(C)], 32'h0000_C0C0);
        check(mem_store[int'(E)] == 32'h0000_E0E0, "R8 second store data", mem_store[int'(E)], 32'h0000_E0E0);

        // R10: non-matching read miss waits for drain
        w0 = wr_cnt;
        cpu_op(1, 0, 0, 0, 1, 0, F, 32'h0000_F0F0, '0, "R10 store", lat);
        cpu_op(0, 0, 0, 0, 1, 0, G, '0, fdef(G), "R10 read data", lat);
        check(wr_cnt == w0 + 1, "R10 store drained before read", wr_cnt, w0 + 1);
        check(lat > MEM_LAT, "R10 read waited", lat, MEM_LAT + 1);

        // R5: remote data not cached
        r0 = rd_cnt;
        cpu_op(0, 0, 1, 0, 0, 0, H, '0, fdef(H), "R5 remote read 1", lat);
        check(last_ext == 1, "R5 remote read external", {31'd0, last_ext}, 32'd1);
        cpu_op(0, 0, 1, 0, 0, 0, H, '0, fdef(H), "R5 remote read 2", lat);
        check(rd_cnt == r0 + 2, "R5 both remote reads to memory", rd_cnt, r0 + 2);

        // R6: remote fetch is cached; cpu_we ignored
        r0 = rd_cnt;
        cpu_op(0, 1, 1, 0, 0, 0, I, '0, fdef(I), "R6 fetch 1", lat);
        cpu_op(1, 1, 1, 0, 0, 0, I, 32'h1111_1111, fdef(I), "R6 fetch 2", lat);
        check(lat == 1, "R6 fetch hit latency", lat, 1);
        check(rd_cnt == r0 + 1, "R6 fetch cached", rd_cnt, r0 + 1);

        // R7: invalidating and remote writes
        cpu_op(1, 0, 0, 1, 1, 1, J, 32'h0000_0A0A, '0, "R7 shared store", lat);
        drain();
        check(last_inval == 1 && last_ext == 1, "R7 shared coherent store invalidates",
              {30'd0, last_inval, last_ext}, 32'd3);
        cpu_op(1, 0, 1, 0, 0, 0, K, 32'h0000_0B0B, '0, "R7 remote store", lat);
        drain();
        check(last_inval == 0 && last_ext == 1, "R7 remote store external only",
              {30'd0, last_inval, last_ext}, 32'd1);

        // R11: snoop with matching tag clears the line
        snoop(A);
        r0 = rd_cnt;
        cpu_op(0, 0, 0, 0, 1, 0, A, '0, 32'hDEAD_0001, "R11 read after snoop data", lat);
        check(rd_cnt == r0 + 1, "R11 snoop cleared line", rd_cnt, r0 + 1);
        snoop(A ^ 16'h0100);
        r0 = rd_cnt;
        cpu_op(0, 0, 0, 0, 1, 0, A, '0, 32'hDEAD_0001, "R11 other-tag snoop data", lat);
        check(rd_cnt == r0, "R11 other-tag snoop kept line", rd_cnt, r0);

        check(sbq.size() == 0, "R13 every request acknowledged", sbq.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule